// File: doc/BRIEF.md
# Constrained Flag-Vector Sweep Generator

This block walks through the legal values of a 30-bit configuration flag word in ascending numeric order and presents them one at a time to a downstream consumer. It exists to drive an exhaustive test of a unit whose behaviour depends on many independent option bits. Some of those bits are not wanted in a given run, and some combinations of them have no meaning.

A programmable mask marks flag positions that must stay zero. The successor of a vector is formed by setting the masked positions to one, adding one, and then clearing the masked positions again. The carry therefore jumps over masked positions and those bits never toggle. Each successor then goes through a fixed legality filter. Candidates the filter rejects are skipped inside the block, one candidate per clock. Only legal vectors are offered.

The output is a valid/ready stream. When `sweep_valid` is high and `sweep_ready` is low, the offered vector stays unchanged until it is accepted. After the last legal vector is accepted, a one-cycle `sweep_done` pulse marks the end of the sweep.

Top module: `flag_sweep_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `sweep_valid` and `sweep_done` are low.
- R2: A `start` pulse seen while idle captures `skip_mask`. In the next cycle `sweep_valid` is high with `sweep_flags` equal to zero.
- R3: Each candidate is ((previous OR mask) + 1) AND NOT mask. No offered vector has a one at a masked position.
- R4: A vector with both bit 23 (write access) and bit 24 (fetch access) set is never offered.
- R5: A vector with both bit 22 (user-mode access) and bit 28 (supervisor execute guard) set is never offered.
- R6: A vector with bit 19 (key read-disable) or bit 20 (key write-disable) set is never offered unless bit 29 (key enable) is also set.
- R7: A vector with bit 17 (directory reserved bit 13) set is never offered unless bit 13 (large page) is also set.
- R8: No offered vector has more than one of bits 15, 16 and 17 set, and none has both bit 6 and bit 7 set.
- R9: Within one sweep, the offered vectors are exactly the legal in-range successors of zero, each offered once and in ascending order.
- R10: While `sweep_valid` is high and `sweep_ready` is low, `sweep_flags` holds and `sweep_valid` stays high.
- R11: When the next candidate reaches 2^30, `sweep_done` pulses for exactly one cycle, `sweep_valid` stays low and the block returns to idle.
- R12: During a sweep, `start` pulses and changes on `skip_mask` have no effect on the offered sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (honoured only while idle) |
| skip_mask | input | 30 | Flag positions forced to zero, captured at start |
| sweep_flags | output | 30 | Offered flag vector |
| sweep_valid | output | 1 | Offered vector is legal and pending |
| sweep_ready | input | 1 | Consumer accepts the offered vector |
| sweep_done | output | 1 | One-cycle pulse after the last vector |

## Verification
The assertions assume that the consumer may drop `sweep_ready` at any time and that `start` and `skip_mask` may change freely during a sweep, since the mask is kept in a register. They also assume that the reset lasts at least one clock. The stimulus uses masks that leave only a few bits free, so each sweep stays short. Random masks are mixed with directed masks that free exactly the bits of one exclusion rule. The stimulus stalls `sweep_ready` at random and pulses `start` with a new mask while a vector is pending, so that back-pressure and ignored restarts are both exercised.

// File: rtl/flag_sweep_pkg.sv
package flag_sweep_pkg;
  localparam int NUM_FLAGS      = 30;
  localparam int POS_LF_R51     = 6;
  localparam int POS_LF_R36     = 7;
  localparam int POS_DR_LARGE   = 13;
  localparam int POS_DR_R51     = 15;
  localparam int POS_DR_R36     = 16;
  localparam int POS_DR_R13     = 17;
  localparam int POS_KEY_RDIS   = 19;
  localparam int POS_KEY_WDIS   = 20;
  localparam int POS_ACC_USER   = 22;
  localparam int POS_ACC_WRITE  = 23;
  localparam int POS_ACC_FETCH  = 24;
  localparam int POS_SUP_XGUARD = 28;
  localparam int POS_KEY_EN     = 29;
  localparam int NUM_RULES      = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_SHOW = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/flag_sweep_step.sv
module flag_sweep_step #(
  parameter int W = 30
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] next_o,
  output logic         wrap_o
);
  localparam int SUM_W = W + 1;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = {1'b0, cur_i | mask_i} + {{(SUM_W-1){1'b0}}, 1'b1};
    next_o = sum[W-1:0] & ~mask_i;
    wrap_o = sum[W];
  end
endmodule

// File: rtl/flag_sweep_legal.sv
module flag_sweep_legal
  import flag_sweep_pkg::*;
#(
  parameter int W = NUM_FLAGS
) (
  input  logic [W-1:0] cand_i,
  output logic         legal_o
);
  logic [NUM_RULES-1:0] viol;
  logic [1:0]           dir_rsv_cnt;
  logic                 unused_bits;

  always_comb begin
    dir_rsv_cnt = {1'b0, cand_i[POS_DR_R51]} + {1'b0, cand_i[POS_DR_R36]}
                + {1'b0, cand_i[POS_DR_R13]};
    viol[0] = cand_i[POS_ACC_WRITE] & cand_i[POS_ACC_FETCH];
    viol[1] = cand_i[POS_ACC_USER] & cand_i[POS_SUP_XGUARD];
    viol[2] = ~cand_i[POS_KEY_EN] & (cand_i[POS_KEY_RDIS] | cand_i[POS_KEY_WDIS]);
    viol[3] = cand_i[POS_DR_R13] & ~cand_i[POS_DR_LARGE];
    viol[4] = dir_rsv_cnt > 2'd1;
    viol[5] = cand_i[POS_LF_R51] & cand_i[POS_LF_R36];
    legal_o = ~|viol;
  end

  assign unused_bits = ^cand_i;
endmodule

// File: rtl/flag_sweep_ctrl.sv
module flag_sweep_ctrl
  import flag_sweep_pkg::*;
#(
  parameter int W = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] mask_i,
  input  logic         ready_i,
  input  logic         legal_i,
  input  logic [W-1:0] step_next_i,
  input  logic         step_wrap_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] mask_o,
  output logic         valid_o,
  output logic         done_o
);
  sweep_state_t state_q;
  logic [W-1:0] flags_q;
  logic [W-1:0] mask_q;
  logic         done_q;
  logic         busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      flags_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mask_q  <= mask_i;
            flags_q <= '0;
            state_q <= ST_SHOW;
          end
        end
        ST_SHOW: begin
          if (ready_i) begin
            if (step_wrap_i) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              flags_q <= step_next_i;
              state_q <= ST_SEEK;
            end
          end
        end
        ST_SEEK: begin
          if (legal_i) begin
            state_q <= ST_SHOW;
          end else if (step_wrap_i) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            flags_q <= step_next_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = state_q != ST_IDLE;
  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign valid_o = state_q == ST_SHOW;
  assign done_o  = done_q;

  AST_VALID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> legal_i); // R4
  AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((flags_q & mask_q) == '0)); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(flags_q))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R11
  AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !valid_o); // R11
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (flags_q != $past(flags_q))) |-> (flags_q > $past(flags_q))); // R9
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mask_q)); // R12
endmodule

// File: rtl/flag_sweep_gen.sv
module flag_sweep_gen
  import flag_sweep_pkg::*;
#(
  parameter int W = NUM_FLAGS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] skip_mask,
  output logic [W-1:0] sweep_flags,
  output logic         sweep_valid,
  input  logic         sweep_ready,
  output logic         sweep_done
);
  logic [W-1:0] cur_flags;
  logic [W-1:0] held_mask;
  logic [W-1:0] succ_flags;
  logic         succ_wrap;
  logic         cur_legal;

  flag_sweep_step #(.W(W)) u_step (
    .cur_i  (cur_flags),
    .mask_i (held_mask),
    .next_o (succ_flags),
    .wrap_o (succ_wrap)
  );

  flag_sweep_legal #(.W(W)) u_legal (
    .cand_i  (cur_flags),
    .legal_o (cur_legal)
  );

  flag_sweep_ctrl #(.W(W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .mask_i      (skip_mask),
    .ready_i     (sweep_ready),
    .legal_i     (cur_legal),
    .step_next_i (succ_flags),
    .step_wrap_i (succ_wrap),
    .flags_o     (cur_flags),
    .mask_o      (held_mask),
    .valid_o     (sweep_valid),
    .done_o      (sweep_done)
  );

  assign sweep_flags = cur_flags;
endmodule

// File: tb/flag_sweep_gen_bench.sv
module flag_sweep_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [29:0] skip_mask = '0;
  logic [29:0] sweep_flags;
  logic        sweep_valid;
  logic        sweep_ready = 1'b0;
  logic        sweep_done;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flag_sweep_gen u_flag_sweep_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_mask(skip_mask),
    .sweep_flags(sweep_flags), .sweep_valid(sweep_valid),
    .sweep_ready(sweep_ready), .sweep_done(sweep_done)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic bit ok_vec(input logic [29:0] f);
    int dr;
    dr = int'(f[15]) + int'(f[16]) + int'(f[17]);
    if (f[23] && f[24]) return 0;
    if (f[22] && f[28]) return 0;
    if (!f[29] && (f[19] || f[20])) return 0;
    if (f[17] && !f[13]) return 0;
    if (dr > 1) return 0;
    if (f[6] && f[7]) return 0;
    return 1;
  endfunction

  function automatic logic [30:0] succ(input logic [29:0] f, input logic [29:0] m);
    logic [30:0] c;
    c = ({1'b0, f | m} + 31'd1) & {1'b1, ~m};
    while (!c[30] && !ok_vec(c[29:0]))
      c = ({1'b0, c[29:0] | m} + 31'd1) & {1'b1, ~m};
    return c;
  endfunction

  task automatic wait_evt(output int kind);
    kind = 2;
    for (int i = 0; i < 64; i++) begin
      if (sweep_valid) begin kind = 0; return; end
      if (sweep_done) begin kind = 1; return; end
      @(negedge clk);
    end
  endtask

  task automatic run_sweep(input logic [29:0] m, input bit stall);
    logic [30:0] expv;
    logic [29:0] held;
    int kind;
    @(negedge clk);
    skip_mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    skip_mask = $urandom; // R12 mask input change after capture
    chk(sweep_valid && sweep_flags == 30'd0, "R2 first vector", {2'b0, sweep_flags}, 32'd0);
    expv = '0;
    for (int n = 0; n < 4096; n++) begin
      wait_evt(kind);
      if (kind != 0) begin
        chk(0, "R9 missing vector", kind, 0);
        break;
      end
      chk(sweep_flags == expv[29:0], "R9 sequence", {2'b0, sweep_flags}, {2'b0, expv[29:0]});
      chk((sweep_flags & m) == 30'd0, "R3 masked bits", {2'b0, sweep_flags & m}, 32'd0);
      chk(ok_vec(sweep_flags), "R8 legality", {2'b0, sweep_flags}, {2'b0, expv[29:0]});
      if (stall) begin
        int s;
        s = $urandom % 4;
        for (int j = 0; j < s; j++) begin
          held = sweep_flags;
          if (j == 0) begin start = 1'b1; skip_mask = $urandom; end
          @(negedge clk);
          start = 1'b0;
          chk(sweep_valid && sweep_flags == held, "R10 R12 stall hold", {2'b0, sweep_flags}, {2'b0, held});
        end
      end
      sweep_ready = 1'b1;
      @(negedge clk);
      sweep_ready = 1'b0;
      expv = succ(expv[29:0], m);
      if (expv[30]) begin
        wait_evt(kind);
        chk(kind == 1, "R11 done expected", kind, 1);
        @(negedge clk);
        chk(!sweep_done && !sweep_valid, "R11 single pulse", {30'd0, sweep_done, sweep_valid}, 0);
        break;
      end
    end
  endtask

  function automatic logic [29:0] free_only(input logic [29:0] keep);
    return ~keep;
  endfunction

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd5171);
    repeat (3) begin
      @(negedge clk);
      chk(!sweep_valid && !sweep_done, "R1 reset", {30'd0, sweep_valid, sweep_done}, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sweep_valid && !sweep_done, "R1 after reset", {30'd0, sweep_valid, sweep_done}, 0);

    run_sweep(free_only((30'd1 << 23) | (30'd1 << 24)), 0);                       // R4
    run_sweep(free_only((30'd1 << 22) | (30'd1 << 28)), 1);                       // R5
    run_sweep(free_only((30'd1 << 19) | (30'd1 << 20) | (30'd1 << 29)), 1);       // R6
    run_sweep(free_only((30'd1 << 13) | (30'd1 << 17)), 0);                       // R7
    run_sweep(free_only((30'd1 << 13) | (30'd1 << 15) | (30'd1 << 16) | (30'd1 << 17)), 1); // R8
    run_sweep(free_only((30'd1 << 6) | (30'd1 << 7) | (30'd1 << 0)), 0);          // R8
    run_sweep(30'h3FFF_FFFF, 0);                                                  // R11 only zero
    for (int t = 0; t < 24; t++) begin
      logic [29:0] keep;
      int k;
      keep = '0;
      k = 1 + ($urandom % 8);
      for (int b = 0; b < k; b++) keep[$urandom % 30] = 1'b1;
      run_sweep(~keep, (t % 2) == 1);                                             // R9 R3
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule